// File: doc/BRIEF.md
# Power-Down Freeze Wrapper

This block sits between a device's external pins and its internal logic and freezes the device while a power-down control pin is held high. On entry it takes a snapshot of the input pins, the output data and the per-bit output enables. The logic then sees only that input snapshot, and the pads show only the captured data and enables. The wrapper also gates the clock that reaches the internal registers, so their state is held as well. Any output that was tri-stated when the freeze began stays tri-stated until the freeze ends.

A configuration bit decides what the control pin does. When the bit is set, the pin is the freeze request, and the logic sees a constant 0 where the pin's value would otherwise appear. When the bit is clear, nothing freezes and the pin is passed to the logic as a plain input. After the control pin falls, a wake-up counter keeps the freeze in place for a set number of clocks. Live inputs and the internal clock are then released together. The clock enable passes through a latch that is transparent while the clock is low, so the gated clock never carries a shortened pulse.

Top module: `pwrdn_hold`

## Requirements
- R1: While running, `core_in` equals `pin_in`, `pad_out` equals `core_out` and `pad_oe` equals `core_oe` combinationally (an enable bit of 1 drives the pad, 0 means high impedance).
- R2: The freeze begins at the first rising clock edge at which `cfg_pd_en` and `pd_pin` are both 1. The snapshot holds the `pin_in`, `core_out` and `core_oe` values present at that edge.
- R3: While frozen, `core_in` shows the snapshot, and changes on `pin_in` have no effect on it.
- R4: While frozen, `pad_out` and `pad_oe` show the snapshot whatever `core_out` and `core_oe` do. An enable bit that was 0 at entry stays 0 for the whole freeze.
- R5: With `cfg_pd_en` = 0, `pd_pin` never causes a freeze and `core_pd` follows `pd_pin`. With `cfg_pd_en` = 1, `core_pd` is 0.
- R6: After the request drops, the freeze continues through WAKE_CYC+1 rising edges. Pass-through resumes right after the (WAKE_CYC+1)-th edge.
- R7: A request that returns during the wake-up count puts the block back into the freeze and keeps the original snapshot.
- R8: `core_clk` shows a rising edge at a `clk` edge only if the block was running and no request was present during the preceding low phase of `clk`. No pulse appears while the block is frozen or waking.
- R9: Synchronous reset puts the block in the running state and clears the snapshot. `core_clk` keeps pulsing while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pd_en | input | 1 | 1: the control pin requests a freeze; 0: the control pin is an ordinary input |
| pd_pin | input | 1 | Power-down control pin |
| pin_in | input | N_IN | External input pins |
| core_out | input | N_OUT | Output data from the internal logic |
| core_oe | input | N_OUT | Output enables from the internal logic |
| core_in | output | N_IN | Input values delivered to the internal logic |
| core_pd | output | 1 | Control pin value as seen by the internal logic |
| pad_out | output | N_OUT | Data driven to the output pads |
| pad_oe | output | N_OUT | Enables driven to the output pads |
| core_clk | output | 1 | Gated clock for the internal registers |

## Verification
The bench enters the freeze with some enables at 0 and then pushes every enable to 1. A design that re-sampled the enables during the freeze would drive pads that should float. It raises the request again in the middle of the wake-up count, where a design that re-captured the snapshot, or kept counting, would show the new pins or release too early. For each cycle it counts the edges on the gated clock, which catches an off-by-one release, a clock that restarts before the inputs do, and a clock that stops during reset. It also runs with the feature bit clear, where a design that still froze, or that masked the control pin, would show up at `core_in` and `core_pd`.

// File: rtl/pwrdn_hold_pkg.sv
package pwrdn_hold_pkg;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HOLD = 2'd1,
        PH_WAKE = 2'd2
    } ph_state_e;

    localparam int unsigned PH_DEF_WAKE = 3;

    // The internal clock may run at the next edge only from the running state with no request
    function automatic logic clk_allowed(input ph_state_e st, input logic req);
        return (st == PH_RUN) && !req;
    endfunction

endpackage

// File: rtl/pwrdn_hold_ctrl.sv
module pwrdn_hold_ctrl
    import pwrdn_hold_pkg::*;
#(
    parameter int unsigned WAKE_CYC = PH_DEF_WAKE
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    output ph_state_e state,
    output logic      frozen,
    output logic      capture,
    output logic      clk_en_d
);
    localparam int unsigned CW   = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    ph_state_e     state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            PH_RUN: begin
                if (req) state_n = PH_HOLD;
            end
            PH_HOLD: begin
                if (!req) begin
                    state_n = PH_WAKE;
                    cnt_n   = '0;
                end
            end
            PH_WAKE: begin
                if (req) begin
                    state_n = PH_HOLD;
                end else if (cnt_q == LAST) begin
                    state_n = PH_RUN;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: state_n = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign state    = state_q;
    assign frozen   = (state_q != PH_RUN);
    assign capture  = (state_q == PH_RUN) && req;
    assign clk_en_d = rst || clk_allowed(state_q, req);

    // R2: a request seen while running leads to the freeze on the next cycle
    assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_RUN && req) |=> (state_q == PH_HOLD));

    // R6: the wake-up count never passes its last value
    assert_wake_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_WAKE) |-> (cnt_q <= LAST));

    // R7: a returning request during wake-up goes back to the freeze
    assert_rewake_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_WAKE && req) |=> (state_q == PH_HOLD));

endmodule

// File: rtl/pwrdn_hold_snap.sv
module pwrdn_hold_snap #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         frozen,
    input  logic [W-1:0] live,
    output logic [W-1:0] view
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (capture) begin
            held_q <= live;
        end
    end

    assign view = frozen ? held_q : live;

    // R3 (and R4 for the output instances): the view does not move during a freeze
    assert_view_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (frozen && $past(frozen)) |-> $stable(view));

endmodule

// File: rtl/pwrdn_hold_cgate.sv
module pwrdn_hold_cgate (
    input  logic clk,
    input  logic en_d,
    output logic gclk
);
    logic en_lat;

    // Transparent while clk is low, so the enable cannot change during a high phase
    always_latch begin
        if (!clk) en_lat = en_d;
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/pwrdn_hold.sv
module pwrdn_hold
    import pwrdn_hold_pkg::*;
#(
    parameter int unsigned N_IN     = 4,
    parameter int unsigned N_OUT    = 4,
    parameter int unsigned WAKE_CYC = PH_DEF_WAKE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_pd_en,
    input  logic             pd_pin,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_IN-1:0]  core_in,
    output logic             core_pd,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe,
    output logic             core_clk
);
    ph_state_e state;
    logic      req, frozen, capture, clk_en_d;

    assign req     = cfg_pd_en & pd_pin;
    assign core_pd = cfg_pd_en ? 1'b0 : pd_pin;

    pwrdn_hold_ctrl #(.WAKE_CYC(WAKE_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .state(state),
        .frozen(frozen), .capture(capture), .clk_en_d(clk_en_d)
    );

    pwrdn_hold_snap #(.W(N_IN)) u_snap_in (
        .clk(clk), .rst(rst), .capture(capture), .frozen(frozen),
        .live(pin_in), .view(core_in)
    );

    pwrdn_hold_snap #(.W(N_OUT)) u_snap_out (
        .clk(clk), .rst(rst), .capture(capture), .frozen(frozen),
        .live(core_out), .view(pad_out)
    );

    pwrdn_hold_snap #(.W(N_OUT)) u_snap_oe (
        .clk(clk), .rst(rst), .capture(capture), .frozen(frozen),
        .live(core_oe), .view(pad_oe)
    );

    pwrdn_hold_cgate u_cgate (
        .clk(clk), .en_d(clk_en_d), .gclk(core_clk)
    );

    // R4: tri-state status at the pads is frozen with the data
    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (frozen && $past(frozen)) |-> $stable(pad_oe));

    // R5: with the feature off the control pin never starts a freeze
    assert_no_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RUN && !cfg_pd_en) |=> (state == PH_RUN));

endmodule

// File: tb/tb_pwrdn_hold.sv
module tb_pwrdn_hold;
    localparam int CLK_P = 10;
    localparam int NV    = 19;

    logic       clk = 1'b0, rst = 1'b1, cfg_pd_en = 1'b1, pd_pin = 1'b0;
    logic [3:0] pin_in = '0, core_out = '0, core_oe = '0;
    logic [3:0] core_in, pad_out, pad_oe;
    logic       core_pd, core_clk;

    int n_chk = 0, n_bad = 0, ccount = 0, cycles = 0;
    bit done = 0;

    pwrdn_hold #(.N_IN(4), .N_OUT(4), .WAKE_CYC(3)) dut (
        .clk(clk), .rst(rst), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .core_in(core_in), .core_pd(core_pd), .pad_out(pad_out),
        .pad_oe(pad_oe), .core_clk(core_clk)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge core_clk) ccount++;
    always @(posedge clk) cycles++;

    // fields: cfg, pd, pin_in, core_out, core_oe | exp core_in, pad_out, pad_oe, core_pd, core_clk pulse
    localparam logic [27:0] VEC [NV] = '{
        {1'b1,1'b0,4'h3,4'h5,4'hF, 4'h3,4'h5,4'hF,1'b0,1'b1},
        {1'b1,1'b0,4'hA,4'h6,4'h3, 4'hA,4'h6,4'h3,1'b0,1'b1},
        {1'b1,1'b1,4'hC,4'h9,4'h1, 4'hC,4'h9,4'h1,1'b0,1'b0},
        {1'b1,1'b1,4'h2,4'h4,4'hF, 4'hC,4'h9,4'h1,1'b0,1'b0},
        {1'b1,1'b0,4'h7,4'h8,4'hE, 4'hC,4'h9,4'h1,1'b0,1'b0},
        {1'b1,1'b0,4'h7,4'h8,4'hE, 4'hC,4'h9,4'h1,1'b0,1'b0},
        {1'b1,1'b0,4'h7,4'h8,4'hE, 4'hC,4'h9,4'h1,1'b0,1'b0},
        {1'b1,1'b0,4'h7,4'h8,4'hE, 4'h7,4'h8,4'hE,1'b0,1'b0},
        {1'b0,1'b1,4'h5,4'h3,4'h2, 4'h5,4'h3,4'h2,1'b1,1'b1},
        {1'b0,1'b0,4'h5,4'h3,4'h2, 4'h5,4'h3,4'h2,1'b0,1'b1},
        {1'b1,1'b1,4'h0,4'hF,4'h0, 4'h0,4'hF,4'h0,1'b0,1'b0},
        {1'b1,1'b1,4'hF,4'hF,4'hF, 4'h0,4'hF,4'h0,1'b0,1'b0},
        {1'b1,1'b0,4'h1,4'h1,4'h1, 4'h0,4'hF,4'h0,1'b0,1'b0},
        {1'b1,1'b1,4'h9,4'h9,4'h9, 4'h0,4'hF,4'h0,1'b0,1'b0},
        {1'b1,1'b0,4'h6,4'h6,4'h6, 4'h0,4'hF,4'h0,1'b0,1'b0},
        {1'b1,1'b0,4'h6,4'h6,4'h6, 4'h0,4'hF,4'h0,1'b0,1'b0},
        {1'b1,1'b0,4'h6,4'h6,4'h6, 4'h0,4'hF,4'h0,1'b0,1'b0},
        {1'b1,1'b0,4'h6,4'h6,4'h6, 4'h6,4'h6,4'h6,1'b0,1'b0},
        {1'b1,1'b0,4'h6,4'h6,4'h6, 4'h6,4'h6,4'h6,1'b0,1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        int c0;
        // R9: reset with a pending request still clocks the core and keeps pass-through
        cfg_pd_en = 1'b1; pd_pin = 1'b1; pin_in = 4'h5; core_out = 4'hA; core_oe = 4'h3;
        rst = 1'b1;
        @(negedge clk); c0 = ccount;
        repeat (3) @(posedge clk);
        #1;
        check("R9 core_clk during reset", ccount - c0, 3);
        check("R9 core_in in reset", core_in, 4'h5);
        check("R9 pad_oe in reset", pad_oe, 4'h3);
        @(negedge clk); pd_pin = 1'b0; rst = 1'b0;
        @(posedge clk); #1;
        check("R9 pad_out after reset", pad_out, 4'hA);
        check("R5 core_pd masked", core_pd, 0);

        // Table walk covering R1..R8
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            @(negedge clk);
            cfg_pd_en = v[27]; pd_pin = v[26];
            pin_in = v[25:22]; core_out = v[21:18]; core_oe = v[17:14];
            c0 = ccount;
            @(posedge clk); #1;
            check($sformatf("R1/R3 core_in step %0d", i), core_in, v[13:10]);
            check($sformatf("R2/R4/R6/R7 pad_out step %0d", i), pad_out, v[9:6]);
            check($sformatf("R4 pad_oe step %0d", i), pad_oe, v[5:2]);
            check($sformatf("R5 core_pd step %0d", i), core_pd, v[1]);
            check($sformatf("R8 core_clk step %0d", i), ccount - c0, v[0]);
        end

        // R9: reset out of a freeze restores pass-through immediately
        @(negedge clk); pd_pin = 1'b1; pin_in = 4'hB;
        @(posedge clk); #1;
        @(negedge clk); pin_in = 4'hD; rst = 1'b1;
        @(posedge clk); #1;
        check("R9 reset leaves freeze", core_in, 4'hD);
        @(negedge clk); rst = 1'b0; pd_pin = 1'b0;
        @(posedge clk); #1;
        check("R1 live after reset", core_in, 4'hD);

        done = 1;
        finish_run();
    end

    initial begin
        wait (cycles > 2000 || done);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

endmodule